// File: doc/BRIEF.md
# Bidirectional Handshake Data Port

This block is one 8-bit data port on shared pins that carries traffic both ways at the same time. A peripheral pushes a byte in by pulling its strobe low. The byte goes into an inbound latch, and the input-buffer-full flag tells the peripheral that the processor has not yet taken it. The processor pushes a byte out with a write pulse. That byte waits in a separate outbound latch under an active-low output-buffer-full flag, and it reaches the pins only while the peripheral holds acknowledge low.

One interrupt request line serves both directions. The inbound request arms when the strobe is released with data pending, and a processor read withdraws it. The outbound request arms when the acknowledge is released, which means the peripheral has taken the byte and the processor may write again. Each direction has its own enable input. The pins are modelled as an output value, an output enable and an input value. Control strobes from the processor and the peripheral are sampled on the clock, and their edges are found against the previous sample.

Top module: `bidir_hs_port`

## Requirements
- R1: After reset, ibf_o is 0, obf_no is 1, intr_o is 0, cpu_rdata_o is 0 and pad_o is 0.
- R2: In every clock in which stb_ni is low, pad_i is captured into the inbound latch, which is shown on cpu_rdata_o after that edge, and ibf_o is set. Capture repeats while the strobe stays low, so the last value is held.
- R3: A rising edge of stb_ni while ibf_o is set arms the inbound request. With ie_in_i high, intr_o then goes high.
- R4: A falling edge of rd_ni withdraws the inbound request and leaves ibf_o set. A later rising edge of rd_ni clears ibf_o. The inbound latch is not changed by either edge.
- R5: A rising edge of wr_ni loads cpu_wdata_i into the outbound latch, which is shown on pad_o. It drives obf_no low and withdraws the outbound request.
- R6: pad_oe_o is high exactly while ack_ni is low. A falling edge of ack_ni drives obf_no high, unless a write rising edge lands in the same clock, in which case the write wins.
- R7: A rising edge of ack_ni, with wr_ni high and obf_no high, arms the outbound request.
- R8: intr_o is the OR of (inbound request AND ie_in_i) and (outbound request AND ie_out_i). With both enables low, intr_o stays 0.
- R9: The two latches are independent. A strobe capture leaves pad_o unchanged, and a write leaves cpu_rdata_o unchanged.
- R10: If stb_ni is low in the same clock as a rising edge of rd_ni, ibf_o remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_ni | input | 1 | Processor read strobe, active low |
| wr_ni | input | 1 | Processor write strobe, active low |
| cpu_wdata_i | input | 8 | Outbound byte from the processor |
| cpu_rdata_o | output | 8 | Inbound latch contents |
| ie_in_i | input | 1 | Inbound interrupt enable |
| ie_out_i | input | 1 | Outbound interrupt enable |
| stb_ni | input | 1 | Peripheral strobe, active low |
| ack_ni | input | 1 | Peripheral acknowledge, active low |
| ibf_o | output | 1 | Input buffer full |
| obf_no | output | 1 | Output buffer full, active low |
| intr_o | output | 1 | Combined interrupt request |
| pad_i | input | 8 | Value seen on the shared pins |
| pad_o | output | 8 | Value driven onto the shared pins |
| pad_oe_o | output | 1 | Pin drive enable |

## Verification
The hardest case to reach is collisions between edges from both sides. Examples are a strobe that is still low when the read strobe rises, and a strobe capture or a write while the opposite latch still holds an unread byte. The bench reaches these by first leaving one direction pending (ibf_o set, or obf_no low). It then drives the conflicting control from the other side on a chosen clock and checks both latches and both flags on the following sample.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int unsigned CtlW = 4;
  typedef struct packed {
    logic stb;
    logic ack;
    logic rd;
    logic wr;
  } hs_ctl_t;
endpackage

// File: rtl/hs_edge_det.sv
module hs_edge_det #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  // idle level of all strobes is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
  assign fall_o = ~sig_i & prev_q;
endmodule

// File: rtl/hs_in_chan.sv
module hs_in_chan #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stb_low_i,
  input  logic          stb_rise_i,
  input  logic          rd_fall_i,
  input  logic          rd_rise_i,
  input  logic [DW-1:0] pad_i,
  output logic [DW-1:0] data_o,
  output logic          ibf_o,
  output logic          req_o
);
  logic [DW-1:0] data_q;
  logic          ibf_q, req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      ibf_q  <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      if (stb_low_i) data_q <= pad_i;
      // a held strobe keeps the buffer full
      if (stb_low_i)      ibf_q <= 1'b1;
      else if (rd_rise_i) ibf_q <= 1'b0;
      if (rd_fall_i)                 req_q <= 1'b0;
      else if (stb_rise_i && ibf_q)  req_q <= 1'b1;
    end
  end

  assign data_o = data_q;
  assign ibf_o  = ibf_q;
  assign req_o  = req_q;
endmodule

// File: rtl/hs_out_chan.sv
module hs_out_chan #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_rise_i,
  input  logic          wr_high_i,
  input  logic          ack_fall_i,
  input  logic          ack_rise_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] data_o,
  output logic          obf_no,
  output logic          req_o
);
  logic [DW-1:0] data_q;
  logic          obf_nq, req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      obf_nq <= 1'b1;
      req_q  <= 1'b0;
    end else begin
      if (wr_rise_i) begin
        data_q <= wdata_i;
        obf_nq <= 1'b0;
        req_q  <= 1'b0;
      end else begin
        if (ack_fall_i) obf_nq <= 1'b1;
        if (ack_rise_i && wr_high_i && obf_nq) req_q <= 1'b1;
      end
    end
  end

  assign data_o = data_q;
  assign obf_no = obf_nq;
  assign req_o  = req_q;
endmodule

// File: rtl/bidir_hs_port.sv
module bidir_hs_port #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_ni,
  input  logic          wr_ni,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic [DW-1:0] cpu_rdata_o,
  input  logic          ie_in_i,
  input  logic          ie_out_i,
  input  logic          stb_ni,
  input  logic          ack_ni,
  output logic          ibf_o,
  output logic          obf_no,
  output logic          intr_o,
  input  logic [DW-1:0] pad_i,
  output logic [DW-1:0] pad_o,
  output logic          pad_oe_o
);
  import hs_pkg::*;

  hs_ctl_t ctl, rise, fall;
  logic    in_req, out_req;

  assign ctl = '{stb: stb_ni, ack: ack_ni, rd: rd_ni, wr: wr_ni};

  hs_edge_det #(.W(CtlW)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (ctl),
    .rise_o (rise),
    .fall_o (fall)
  );

  hs_in_chan #(.DW(DW)) u_in (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stb_low_i  (~ctl.stb),
    .stb_rise_i (rise.stb),
    .rd_fall_i  (fall.rd),
    .rd_rise_i  (rise.rd),
    .pad_i      (pad_i),
    .data_o     (cpu_rdata_o),
    .ibf_o      (ibf_o),
    .req_o      (in_req)
  );

  hs_out_chan #(.DW(DW)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_rise_i  (rise.wr),
    .wr_high_i  (ctl.wr),
    .ack_fall_i (fall.ack),
    .ack_rise_i (rise.ack),
    .wdata_i    (cpu_wdata_i),
    .data_o     (pad_o),
    .obf_no     (obf_no),
    .req_o      (out_req)
  );

  assign pad_oe_o = ~ack_ni;
  assign intr_o   = (in_req & ie_in_i) | (out_req & ie_out_i);
endmodule

// File: rtl/bidir_hs_port_chk.sv
module bidir_hs_port_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rd_ni,
  input logic          wr_ni,
  input logic [DW-1:0] cpu_wdata_i,
  input logic [DW-1:0] cpu_rdata_o,
  input logic          ie_in_i,
  input logic          ie_out_i,
  input logic          stb_ni,
  input logic          ack_ni,
  input logic          ibf_o,
  input logic          obf_no,
  input logic          intr_o,
  input logic [DW-1:0] pad_i,
  input logic [DW-1:0] pad_o,
  input logic          pad_oe_o
);
  logic rd_p, wr_p, ack_p;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_p <= 1'b1; wr_p <= 1'b1; ack_p <= 1'b1;
    end else begin
      rd_p <= rd_ni; wr_p <= wr_ni; ack_p <= ack_ni;
    end
  end

  a_r2_stb_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_ni |=> (ibf_o && cpu_rdata_o == $past(pad_i)));

  a_r4_rd_rise_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ni && !rd_p && stb_ni) |=> !ibf_o);

  a_r4_rd_fall_keeps_ibf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_ni && rd_p && ibf_o) |=> ibf_o);

  a_r5_wr_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ni && !wr_p) |=> (!obf_no && pad_o == $past(cpu_wdata_i)));

  a_r6_ack_fall_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_ni && ack_p && !(wr_ni && !wr_p)) |=> obf_no);

  a_r8_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ie_in_i && !ie_out_i) |-> !intr_o);

  a_r9_out_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_ni && !wr_p) |=> $stable(pad_o));
endmodule

bind bidir_hs_port bidir_hs_port_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_ni(rd_ni), .wr_ni(wr_ni),
  .cpu_wdata_i(cpu_wdata_i), .cpu_rdata_o(cpu_rdata_o),
  .ie_in_i(ie_in_i), .ie_out_i(ie_out_i), .stb_ni(stb_ni), .ack_ni(ack_ni),
  .ibf_o(ibf_o), .obf_no(obf_no), .intr_o(intr_o),
  .pad_i(pad_i), .pad_o(pad_o), .pad_oe_o(pad_oe_o)
);

// File: tb/bidir_hs_port_bench.sv
module bidir_hs_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_n = 1'b1, wr_n = 1'b1, stb_n = 1'b1, ack_n = 1'b1;
  logic       ie_in = 1'b0, ie_out = 1'b0;
  logic [7:0] wdata = '0, pad_in = '0;
  logic [7:0] rdata, pad_out;
  logic       ibf, obf_n, intr, pad_oe;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #4ns clk = ~clk;

  bidir_hs_port u_bidir_hs_port (
    .clk_i(clk), .rst_ni(rst_n), .rd_ni(rd_n), .wr_ni(wr_n),
    .cpu_wdata_i(wdata), .cpu_rdata_o(rdata),
    .ie_in_i(ie_in), .ie_out_i(ie_out), .stb_ni(stb_n), .ack_ni(ack_n),
    .ibf_o(ibf), .obf_no(obf_n), .intr_o(intr),
    .pad_i(pad_in), .pad_o(pad_out), .pad_oe_o(pad_oe)
  );

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "ibf", {7'd0, ibf}, 8'd0);
    chk("R1", "obf_n", {7'd0, obf_n}, 8'd1);
    chk("R1", "intr", {7'd0, intr}, 8'd0);
    chk("R1", "rdata", rdata, 8'h00);
    chk("R1", "pad_o", pad_out, 8'h00);
    chk("R6", "oe idle", {7'd0, pad_oe}, 8'd0);
  endtask

  task automatic t_inbound();
    pad_in = 8'hA5; stb_n = 1'b0; step();
    chk("R2", "ibf set", {7'd0, ibf}, 8'd1);
    chk("R2", "capture", rdata, 8'hA5);
    pad_in = 8'h3C; step();
    chk("R2", "recapture", rdata, 8'h3C);
    stb_n = 1'b1; pad_in = 8'h77; step();
    chk("R2", "held", rdata, 8'h3C);
    chk("R8", "masked in", {7'd0, intr}, 8'd0);
    ie_in = 1'b1; #1ns;
    chk("R3", "in intr", {7'd0, intr}, 8'd1);
    rd_n = 1'b0; step();
    chk("R4", "rd fall intr", {7'd0, intr}, 8'd0);
    chk("R4", "rd fall ibf", {7'd0, ibf}, 8'd1);
    rd_n = 1'b1; step();
    chk("R4", "rd rise ibf", {7'd0, ibf}, 8'd0);
    chk("R4", "data kept", rdata, 8'h3C);
  endtask

  task automatic t_outbound();
    ie_out = 1'b1;
    wdata = 8'h5A; wr_n = 1'b0; step();
    wr_n = 1'b1; step();
    chk("R5", "obf low", {7'd0, obf_n}, 8'd0);
    chk("R5", "pad_o", pad_out, 8'h5A);
    chk("R6", "oe off", {7'd0, pad_oe}, 8'd0);
    chk("R7", "no early intr", {7'd0, intr}, 8'd0);
    ack_n = 1'b0; #1ns;
    chk("R6", "oe on", {7'd0, pad_oe}, 8'd1);
    step();
    chk("R6", "obf released", {7'd0, obf_n}, 8'd1);
    ack_n = 1'b1; step();
    chk("R7", "out intr", {7'd0, intr}, 8'd1);
    chk("R6", "oe off again", {7'd0, pad_oe}, 8'd0);
    ie_out = 1'b0; #1ns;
    chk("R8", "masked out", {7'd0, intr}, 8'd0);
    ie_out = 1'b1;
    wdata = 8'hC3; wr_n = 1'b0; step();
    wr_n = 1'b1; step();
    chk("R5", "write withdraws", {7'd0, intr}, 8'd0);
    chk("R5", "pad_o new", pad_out, 8'hC3);
  endtask

  task automatic t_independence();
    pad_in = 8'hFF; stb_n = 1'b0; step();
    stb_n = 1'b1; step();
    chk("R9", "out latch kept", pad_out, 8'hC3);
    chk("R9", "obf pending", {7'd0, obf_n}, 8'd0);
    chk("R3", "in intr again", {7'd0, intr}, 8'd1);
    wdata = 8'h11; wr_n = 1'b0; step();
    wr_n = 1'b1; step();
    chk("R9", "in latch kept", rdata, 8'hFF);
    chk("R9", "ibf kept", {7'd0, ibf}, 8'd1);
  endtask

  task automatic t_overlap();
    rd_n = 1'b0; step();
    pad_in = 8'h42; stb_n = 1'b0; rd_n = 1'b1; step();
    chk("R10", "ibf held", {7'd0, ibf}, 8'd1);
    chk("R10", "new data", rdata, 8'h42);
    stb_n = 1'b1; step();
    ie_in = 1'b0; ie_out = 1'b0; #1ns;
    chk("R8", "both masked", {7'd0, intr}, 8'd0);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_inbound();
    t_outbound();
    t_independence();
    t_overlap();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule